// File: doc/BRIEF.md
# Flash Read Response Multiplexer

This block answers every read aimed at a NOR flash model. The command sequencer tells it which mode the device is in, and the block picks the source of the returned word. In plain read mode the source is the storage array, with 1, 2 or 4 bytes packed in either byte order. In identification mode it is a set of identification words. While a program or erase runs it is the status byte. In query mode it is the query table. The block owns the status byte, which the sequencer loads. Every status read flips bit 6 of that byte, so software can poll it and watch it toggle.

A counter tracks plain reads made while the device is out of direct array mode and no command is pending. Once the count passes a limit, the block restores direct array mode by itself. A sequencer pulse, issued when software writes from read mode, leaves direct mode and clears the counter. Array bytes come from an external port that returns four consecutive bytes starting at the request address. Query bytes come from an external table indexed by the special-mode offset. The answer is registered.

Top module: `flrd_read_mux`

## Requirements
- R1: `rd_valid` is high in exactly the cycle after a cycle with `rd_req` high, and `rd_data` holds the answer in that cycle. After reset `rd_valid` and `cmd_reset` are 0 and `direct_mode` is 1.
- R2: With `mode` 0x00 or 0x80, the answer is array data. `rd_size` selects the width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. Byte k comes from address `rd_addr`+k. When `rd_be`=1 the byte at `rd_addr` sits in the most significant used byte lane; when `rd_be`=0 it sits in lane 0. Unused upper bits are 0.
- R3: With `mode` 0x90, offset 0 returns identification word 0 and offset 1 returns word 1, each zero-extended. Offset 2 returns 0.
- R4: With `mode` 0x90, offsets 0x0E and 0x0F return identification words 2 and 3. The block returns array data instead when the selected word's low byte is 0xFF, and for every other offset.
- R5: With `mode` 0xA0, 0x10 or 0x30, the answer is the status byte zero-extended. Each such read inverts status bit 6 for the following read. A `stat_wr` pulse loads `stat_wdata` into the status byte, and the status byte is 0 after reset.
- R6: With `mode` 0x98, `cfi_idx` carries the offset and the answer is `cfi_byte`. An offset greater than `CFI_LEN` (0x52) returns 0.
- R7: Each read with `direct_mode`=0 and `cmd_pending`=0 adds 1 to a counter. Direct mode returns when the count exceeds `LAZY_LIMIT` (42), that is, on the 43rd such read. Reads with `cmd_pending`=1 do not count.
- R8: A `leave_direct` pulse clears `direct_mode` and the counter.
- R9: The special-mode offset is `rd_addr[7:0]` shifted right by 0, 1 or 2 for device widths of 1, 2 or 4 bytes. Address bits above bit 7 have no effect on it.
- R10: Any other `mode` value returns array data as in R2. It also raises `cmd_reset` together with `rd_valid` for that one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_size | input | 2 | Access width: 0 byte, 1 half, 2 word |
| rd_be | input | 1 | Big-endian packing of array reads |
| mode | input | 8 | Current command mode from the sequencer |
| cmd_pending | input | 1 | Sequencer is inside a command sequence |
| leave_direct | input | 1 | Write from read mode: leave direct mode, clear counter |
| stat_wr | input | 1 | Load the status byte |
| stat_wdata | input | 8 | Status value to load |
| arr_addr | output | ADDR_W | Array byte address to fetch |
| arr_rdata | input | 32 | Four array bytes from arr_addr upward, byte 0 in bits 7:0 |
| cfi_idx | output | 8 | Query table index |
| cfi_byte | input | 8 | Query table byte at cfi_idx |
| rd_data | output | 32 | Registered read answer |
| rd_valid | output | 1 | Answer valid |
| cmd_reset | output | 1 | Unknown mode seen; sequencer should reset |
| direct_mode | output | 1 | Device is in direct array-read mode |

## Verification
The array reads cover all three widths in both byte orders, at an address near the top of the space so that the byte walk wraps. An array pattern that depends on every address bit shows any lane swap or wrong byte pick. Identification reads try each special offset, an offset that must fall back to array data, and an address with high bits set. This separates the identification path from the array path and shows the offset shift. The test reaches a query offset exactly at the table length and one just above it, which exposes an off-by-one in the limit. The lazy counter runs through 42 reads that must not restore direct mode and a 43rd that must, with a pending-command read mixed in that must not count.

// File: rtl/flrd_pkg.sv
package flrd_pkg;

  localparam logic [7:0] MODE_READ      = 8'h00;
  localparam logic [7:0] MODE_ERASE_SET = 8'h80;
  localparam logic [7:0] MODE_AUTOSEL   = 8'h90;
  localparam logic [7:0] MODE_PROGRAM   = 8'hA0;
  localparam logic [7:0] MODE_CHIP_ERS  = 8'h10;
  localparam logic [7:0] MODE_SECT_ERS  = 8'h30;
  localparam logic [7:0] MODE_QUERY     = 8'h98;

  typedef enum logic [2:0] {
    SRC_ARRAY,
    SRC_IDENT,
    SRC_ZERO,
    SRC_STATUS,
    SRC_QUERY
  } src_e;

  // Special-mode offset: low address byte scaled by the device width.
  function automatic logic [7:0] mode_offset(input logic [7:0] lo, input int unsigned dev_bytes);
    if (dev_bytes == 4) return lo >> 2;
    if (dev_bytes == 2) return lo >> 1;
    return lo;
  endfunction

  // Pack array bytes (raw byte k = address+k) into the answer word.
  function automatic logic [31:0] pack_bytes(input logic [31:0] raw, input logic [1:0] sz,
                                             input logic be);
    logic [31:0] r;
    r = '0;
    case (sz)
      2'd0:    r = {24'h0, raw[7:0]};
      2'd1:    r = be ? {16'h0, raw[7:0], raw[15:8]} : {16'h0, raw[15:0]};
      default: r = be ? {raw[7:0], raw[15:8], raw[23:16], raw[31:24]} : raw;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/flrd_decode.sv
module flrd_decode
  import flrd_pkg::*;
#(
  parameter logic [15:0] ID0     = 16'h0001,
  parameter logic [15:0] ID1     = 16'h22A8,
  parameter logic [15:0] ID2     = 16'h2210,
  parameter logic [15:0] ID3     = 16'h00FF,
  parameter logic [7:0]  CFI_LEN = 8'h52
) (
  input  logic [7:0]  mode,
  input  logic [7:0]  boff,
  output src_e        src,
  output logic [15:0] id_word,
  output logic        unknown
);

  always_comb begin
    src     = SRC_ARRAY;
    id_word = '0;
    unknown = 1'b0;
    case (mode)
      MODE_READ, MODE_ERASE_SET: src = SRC_ARRAY;
      MODE_AUTOSEL: begin
        case (boff)
          8'h00: begin src = SRC_IDENT; id_word = ID0; end
          8'h01: begin src = SRC_IDENT; id_word = ID1; end
          8'h02: src = SRC_ZERO;
          8'h0E: if (ID2[7:0] != 8'hFF) begin src = SRC_IDENT; id_word = ID2; end
          8'h0F: if (ID3[7:0] != 8'hFF) begin src = SRC_IDENT; id_word = ID3; end
          default: src = SRC_ARRAY;
        endcase
      end
      MODE_PROGRAM, MODE_CHIP_ERS, MODE_SECT_ERS: src = SRC_STATUS;
      MODE_QUERY: src = (boff > CFI_LEN) ? SRC_ZERO : SRC_QUERY;
      default: begin
        src     = SRC_ARRAY;
        unknown = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/flrd_status_reg.sv
module flrd_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       toggle,
  output logic [7:0] status_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status_q <= 8'h00;
    else if (load)   status_q <= load_val;
    else if (toggle) status_q <= status_q ^ 8'h40;
  end

endmodule

// File: rtl/flrd_lazy_ctr.sv
module flrd_lazy_ctr #(
  parameter int unsigned LAZY_LIMIT = 42
) (
  input  logic clk,
  input  logic rst_n,
  input  logic plain_rd,
  input  logic leave,
  output logic direct_mode
);

  localparam int unsigned CNT_W = $clog2(LAZY_LIMIT + 2);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      direct_mode <= 1'b1;
    end else if (leave) begin
      cnt_q       <= '0;
      direct_mode <= 1'b0;
    end else if (plain_rd) begin
      cnt_q <= cnt_inc;
      if (cnt_inc > CNT_W'(LAZY_LIMIT)) direct_mode <= 1'b1;
    end
  end

endmodule

// File: rtl/flrd_read_mux.sv
module flrd_read_mux
  import flrd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DEV_BYTES  = 2,
  parameter logic [15:0] ID0        = 16'h0001,
  parameter logic [15:0] ID1        = 16'h22A8,
  parameter logic [15:0] ID2        = 16'h2210,
  parameter logic [15:0] ID3        = 16'h00FF,
  parameter logic [7:0]  CFI_LEN    = 8'h52,
  parameter int unsigned LAZY_LIMIT = 42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_size,
  input  logic              rd_be,
  input  logic [7:0]        mode,
  input  logic              cmd_pending,
  input  logic              leave_direct,
  input  logic              stat_wr,
  input  logic [7:0]        stat_wdata,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [31:0]       arr_rdata,
  output logic [7:0]        cfi_idx,
  input  logic [7:0]        cfi_byte,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              cmd_reset,
  output logic              direct_mode
);

  logic [7:0]  boff;
  src_e        src;
  logic [15:0] id_word;
  logic        ev_unknown;
  logic        ev_status_rd;
  logic        ev_plain_rd;
  logic [7:0]  status_q;
  logic [31:0] answer;

  assign boff     = mode_offset(rd_addr[7:0], DEV_BYTES);
  assign arr_addr = rd_addr;
  assign cfi_idx  = boff;

  flrd_decode #(
    .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3), .CFI_LEN(CFI_LEN)
  ) u_decode (
    .mode(mode), .boff(boff), .src(src), .id_word(id_word), .unknown(ev_unknown)
  );

  assign ev_status_rd = rd_req && (src == SRC_STATUS);
  assign ev_plain_rd  = rd_req && !direct_mode && !cmd_pending;

  flrd_status_reg u_status (
    .clk(clk), .rst_n(rst_n), .load(stat_wr), .load_val(stat_wdata),
    .toggle(ev_status_rd), .status_q(status_q)
  );

  flrd_lazy_ctr #(.LAZY_LIMIT(LAZY_LIMIT)) u_lazy (
    .clk(clk), .rst_n(rst_n), .plain_rd(ev_plain_rd), .leave(leave_direct),
    .direct_mode(direct_mode)
  );

  always_comb begin
    case (src)
      SRC_IDENT:  answer = {16'h0, id_word};
      SRC_ZERO:   answer = '0;
      SRC_STATUS: answer = {24'h0, status_q};
      SRC_QUERY:  answer = {24'h0, cfi_byte};
      default:    answer = pack_bytes(arr_rdata, rd_size, rd_be);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      cmd_reset <= 1'b0;
    end else begin
      rd_valid  <= rd_req;
      cmd_reset <= rd_req && ev_unknown;
      if (rd_req) rd_data <= answer;
    end
  end

endmodule

// File: rtl/flrd_read_mux_chk.sv
module flrd_read_mux_chk #(
  parameter logic [7:0] CFI_LEN = 8'h52
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic [7:0]  mode,
  input logic [7:0]  boff,
  input logic        leave_direct,
  input logic        stat_wr,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic        cmd_reset,
  input logic        direct_mode,
  input logic [7:0]  status_q,
  input logic        ev_status_rd,
  input logic        ev_plain_rd,
  input logic        ev_unknown
);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  assert_valid_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  assert_status_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_status_rd && !stat_wr) |=> (status_q == ($past(status_q) ^ 8'h40)));
  assert_query_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && mode == 8'h98 && boff > CFI_LEN) |=> (rd_data == 32'h0));
  assert_restore_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(direct_mode) |-> $past(ev_plain_rd));
  assert_leave_direct_R8: assert property (@(posedge clk) disable iff (!rst_n)
    leave_direct |=> !direct_mode);
  assert_unknown_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && ev_unknown) |=> cmd_reset);

endmodule

bind flrd_read_mux flrd_read_mux_chk #(.CFI_LEN(CFI_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .mode(mode), .boff(boff),
  .leave_direct(leave_direct), .stat_wr(stat_wr), .rd_valid(rd_valid),
  .rd_data(rd_data), .cmd_reset(cmd_reset), .direct_mode(direct_mode),
  .status_q(status_q), .ev_status_rd(ev_status_rd), .ev_plain_rd(ev_plain_rd),
  .ev_unknown(ev_unknown)
);

// File: tb/flrd_read_mux_test.sv
module flrd_read_mux_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        rd_req = 0;
  logic [15:0] rd_addr = 0;
  logic [1:0]  rd_size = 0;
  logic        rd_be = 0;
  logic [7:0]  mode = 0;
  logic        cmd_pending = 0;
  logic        leave_direct = 0;
  logic        stat_wr = 0;
  logic [7:0]  stat_wdata = 0;
  logic [15:0] arr_addr;
  logic [31:0] arr_rdata;
  logic [7:0]  cfi_idx;
  logic [7:0]  cfi_byte;
  logic [31:0] rd_data;
  logic        rd_valid, cmd_reset, direct_mode;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_b(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign arr_rdata = {mem_b(arr_addr + 16'd3), mem_b(arr_addr + 16'd2),
                      mem_b(arr_addr + 16'd1), mem_b(arr_addr)};
  assign cfi_byte  = cfi_idx + 8'h30;

  flrd_read_mux uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_be(rd_be), .mode(mode), .cmd_pending(cmd_pending), .leave_direct(leave_direct),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
    .cfi_idx(cfi_idx), .cfi_byte(cfi_byte), .rd_data(rd_data), .rd_valid(rd_valid),
    .cmd_reset(cmd_reset), .direct_mode(direct_mode)
  );

  // Expected array word built byte by byte from the requirement text.
  function automatic logic [31:0] exp_arr(input logic [15:0] a, input int n, input logic be);
    logic [31:0] r = 0;
    for (int k = 0; k < n; k++) begin
      if (be) r = (r << 8) | 32'(mem_b(a + 16'(k)));
      else    r = r | (32'(mem_b(a + 16'(k))) << (8 * k));
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] sz, input logic be,
                    output logic [31:0] d, output logic cr);
    @(negedge clk);
    rd_req = 1; rd_addr = a; rd_size = sz; rd_be = be;
    @(negedge clk);
    rd_req = 0;
    d = rd_data; cr = cmd_reset;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(rd_valid), 0);
    chk("R1 cmd_reset after reset", 32'(cmd_reset), 0);
    chk("R1 direct after reset", 32'(direct_mode), 1);
  endtask

  task automatic t_array;
    logic [31:0] d; logic cr;
    mode = 8'h00;
    @(negedge clk);
    rd_req = 1; rd_addr = 16'h1234; rd_size = 2; rd_be = 0;
    @(negedge clk);
    rd_req = 0;
    chk("R1 valid one cycle after req", 32'(rd_valid), 1);
    chk("R2 word le", rd_data, exp_arr(16'h1234, 4, 0));
    @(negedge clk);
    chk("R1 valid drops", 32'(rd_valid), 0);
    rd(16'h1234, 2, 1, d, cr); chk("R2 word be", d, exp_arr(16'h1234, 4, 1));
    rd(16'hFFFE, 2, 1, d, cr); chk("R2 word be wrap", d, exp_arr(16'hFFFE, 4, 1));
    rd(16'h0A71, 1, 0, d, cr); chk("R2 half le", d, exp_arr(16'h0A71, 2, 0));
    rd(16'h0A71, 1, 1, d, cr); chk("R2 half be", d, exp_arr(16'h0A71, 2, 1));
    rd(16'hC3C5, 0, 1, d, cr); chk("R2 byte", d, exp_arr(16'hC3C5, 1, 1));
    mode = 8'h80;
    rd(16'h4321, 2, 0, d, cr); chk("R2 erase setup reads array", d, exp_arr(16'h4321, 4, 0));
    chk("R2 no cmd_reset", 32'(cr), 0);
  endtask

  task automatic t_ident;
    logic [31:0] d; logic cr;
    mode = 8'h90;
    rd(16'h0000, 1, 0, d, cr); chk("R3 id0", d, 32'h0001);
    rd(16'h0002, 1, 0, d, cr); chk("R3 id1", d, 32'h22A8);
    rd(16'h0004, 1, 0, d, cr); chk("R3 protect zero", d, 32'h0);
    rd(16'h001C, 1, 0, d, cr); chk("R4 id2", d, 32'h2210);
    rd(16'h001E, 1, 0, d, cr); chk("R4 id3 fallback", d, exp_arr(16'h001E, 2, 0));
    rd(16'h0006, 2, 1, d, cr); chk("R4 other offset", d, exp_arr(16'h0006, 4, 1));
    rd(16'h0302, 1, 0, d, cr); chk("R9 high bits ignored", d, 32'h22A8);
  endtask

  task automatic t_status;
    logic [31:0] d; logic cr;
    mode = 8'hA0;
    rd(16'h0000, 0, 0, d, cr); chk("R5 status reset value", d, 32'h00);
    rd(16'h0000, 0, 0, d, cr); chk("R5 toggled once", d, 32'h40);
    @(negedge clk); stat_wr = 1; stat_wdata = 8'h80;
    @(negedge clk); stat_wr = 0;
    rd(16'h0010, 2, 0, d, cr); chk("R5 loaded status", d, 32'h80);
    rd(16'h0010, 2, 0, d, cr); chk("R5 bit6 toggles", d, 32'hC0);
    mode = 8'h10;
    rd(16'h0010, 2, 0, d, cr); chk("R5 chip erase mode", d, 32'h80);
    mode = 8'h30;
    rd(16'h0010, 2, 0, d, cr); chk("R5 sector erase mode", d, 32'hC0);
  endtask

  task automatic t_query;
    logic [31:0] d; logic cr;
    mode = 8'h98;
    rd(16'h0020, 0, 0, d, cr); chk("R6 table byte", d, 32'h40);
    rd(16'h00A4, 0, 0, d, cr); chk("R6 offset at length", d, 32'h82);
    rd(16'h00A6, 0, 0, d, cr); chk("R6 beyond length zero", d, 32'h0);
    rd(16'h0521, 0, 0, d, cr); chk("R9 offset shift", d, 32'h40);
  endtask

  task automatic t_lazy;
    logic [31:0] d; logic cr;
    mode = 8'h00;
    @(negedge clk); leave_direct = 1;
    @(negedge clk); leave_direct = 0;
    chk("R8 leave clears direct", 32'(direct_mode), 0);
    cmd_pending = 1;
    rd(16'h0000, 0, 0, d, cr);
    cmd_pending = 0;
    for (int i = 0; i < 42; i++) rd(16'(i), 0, 0, d, cr);
    chk("R7 42 reads keep indirect", 32'(direct_mode), 0);
    rd(16'h0000, 0, 0, d, cr);
    chk("R7 43rd read restores direct", 32'(direct_mode), 1);
    @(negedge clk); leave_direct = 1;
    @(negedge clk); leave_direct = 0;
    for (int i = 0; i < 42; i++) rd(16'(i), 0, 0, d, cr);
    chk("R8 counter cleared by leave", 32'(direct_mode), 0);
    rd(16'h0000, 0, 0, d, cr);
    chk("R7 restored again", 32'(direct_mode), 1);
  endtask

  task automatic t_unknown;
    logic [31:0] d; logic cr;
    mode = 8'h55;
    rd(16'h2468, 1, 1, d, cr);
    chk("R10 unknown reads array", d, exp_arr(16'h2468, 2, 1));
    chk("R10 cmd_reset raised", 32'(cr), 1);
    mode = 8'h00;
    rd(16'h2468, 1, 1, d, cr);
    chk("R10 cmd_reset only for unknown", 32'(cr), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_array();
    t_ident();
    t_status();
    t_query();
    t_lazy();
    t_unknown();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule